// File: doc/BRIEF.md
# 8x8 Tile Address Generator

This block produces the memory addresses a block-transform engine needs to walk an image held in raster order as a grid of non-overlapping 8x8 tiles. A configuration strobe captures the image width and height and restarts the walk at the top-left tile. The engine then supplies an element index from 0 to 63 within the tile. The block answers with the address to read for the tile being fetched. In the same cycle it gives the address to write for the tile fetched two tile cycles earlier. This fits a three-stage fetch, compute and store pipeline.

A tile-advance strobe closes one tile cycle and moves the read window one tile to the right. At the right edge the window wraps to the first column of the next tile row. The block drives enables for both sides. They mark the two fill cycles, when nothing is written yet, and the two drain cycles, when nothing is left to read. A flag marks the last tile on each side, and a done flag follows the store of the final tile. Address and enable outputs are combinational from the element index and the internal window state.

Top module: `tile_addr_gen`

## Requirements
- R1: After reset, and until the first configuration load, src_en_o, dst_en_o, last_read_o, last_write_o and done_o are all 0.
- R2: A cycle with cfg_load_i high captures width and height, clears any run in progress, and starts a new walk: in the next cycle src_en_o is 1, dst_en_o is 0, done_o is 0, and the read tile origin is row 0, column 0.
- R3: While src_en_o is 1, src_addr_o = (row0 + idx[5:3]) * width + col0 + idx[2:0] for element index idx and read tile origin (row0, col0), computed in 32 bits.
- R4: Each accepted tile advance moves the read origin right by 8 columns. When col0 + 8 equals the width, it goes to column 0 and down 8 rows instead, so tiles are visited in raster order. Width and height are nonzero multiples of 8.
- R5: While dst_en_o is 1, dst_addr_o uses the formula of R3 with the origin of the tile that was read two tile advances earlier.
- R6: With T = (width/8)*(height/8) tiles, dst_en_o is 0 in tile cycles 0 and 1 after a load and 1 in tile cycles 2 to T+1.
- R7: src_en_o is 1 in tile cycles 0 to T-1 and 0 from cycle T on (the drain).
- R8: last_read_o is 1 only in tile cycle T-1.
- R9: last_write_o is 1 only in tile cycle T+1. The advance that ends that cycle sets done_o, which then stays 1 until the next load. Further advances change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Capture size and restart the walk |
| cfg_width_i | input | 16 | Image width in pixels (multiple of 8) |
| cfg_height_i | input | 16 | Image height in pixels (multiple of 8) |
| elem_idx_i | input | 6 | Element index within the tile, row in [5:3], column in [2:0] |
| tile_adv_i | input | 1 | End of the current tile cycle |
| src_addr_o | output | 32 | Read address for the current tile |
| src_en_o | output | 1 | Read address is meaningful |
| dst_addr_o | output | 32 | Write address for the tile read two cycles earlier |
| dst_en_o | output | 1 | Write address is meaningful |
| last_read_o | output | 1 | Current read tile is the last tile |
| last_write_o | output | 1 | Current write tile is the last tile |
| done_o | output | 1 | Last tile has been stored |

## Verification
A wrong window origin shows at once on src_addr_o. Two tile cycles later the same wrong origin shows on dst_addr_o, so every element index of each tile is compared on both ports. A fault in the lag line or in the last-tile detection moves the edges of the enables and flags by a whole tile cycle. That is visible in the first run that crosses the row wrap. Runs with a single tile, with wide and with tall images, with advances after done and with a reload in mid-run separate wrap, drain and restart faults.

// File: rtl/tile_pkg.sv
package tile_pkg;
  localparam int unsigned DIM_W     = 16;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned TILE_LOG2 = 3;
  localparam int unsigned LAG       = 2;
  localparam int unsigned TILE      = 1 << TILE_LOG2;
  localparam int unsigned IDX_W     = 2 * TILE_LOG2;

  typedef struct packed {
    logic             valid;
    logic             last;
    logic [DIM_W-1:0] row;
    logic [DIM_W-1:0] col;
  } tile_pos_t;
endpackage

// File: rtl/tile_window_ctr.sv
module tile_window_ctr
  import tile_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  output tile_pos_t        pos_o
);
  logic [DIM_W-1:0] row_q, col_q;
  logic             valid_q;
  logic [DIM_W:0]   col_nx, row_nx;
  logic             row_end, col_end;

  assign col_nx  = {1'b0, col_q} + (DIM_W+1)'(TILE);
  assign row_nx  = {1'b0, row_q} + (DIM_W+1)'(TILE);
  assign row_end = (col_nx == {1'b0, width_i});
  assign col_end = (row_nx == {1'b0, height_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q   <= '0;
      col_q   <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      row_q   <= '0;
      col_q   <= '0;
      valid_q <= 1'b1;
    end else if (adv_i && valid_q) begin
      if (row_end && col_end) begin
        valid_q <= 1'b0;              // drain: hold origin, stop reading
      end else if (row_end) begin
        col_q <= '0;
        row_q <= row_nx[DIM_W-1:0];
      end else begin
        col_q <= col_nx[DIM_W-1:0];
      end
    end
  end

  always_comb begin
    pos_o.valid = valid_q;
    pos_o.last  = row_end && col_end;
    pos_o.row   = row_q;
    pos_o.col   = col_q;
  end
endmodule

// File: rtl/tile_lag_pipe.sv
module tile_lag_pipe
  import tile_pkg::*;
#(
  parameter int unsigned DEPTH = LAG
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      adv_i,
  input  tile_pos_t pos_i,
  output tile_pos_t pos_o
);
  tile_pos_t stage_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    tile_pos_t src;
    if (s == 0) begin : g_head
      assign src = pos_i;
    end else begin : g_body
      assign src = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (clr_i)  stage_q[s] <= '0;
      else if (adv_i)  stage_q[s] <= src;
    end
  end

  assign pos_o = stage_q[DEPTH-1];
endmodule

// File: rtl/tile_addr_calc.sv
module tile_addr_calc
  import tile_pkg::*;
(
  input  logic [DIM_W-1:0]  row0_i,
  input  logic [DIM_W-1:0]  col0_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] row_abs, col_abs;

  assign row_abs = ADDR_W'(row0_i) + ADDR_W'(idx_i[IDX_W-1:TILE_LOG2]);
  assign col_abs = ADDR_W'(col0_i) + ADDR_W'(idx_i[TILE_LOG2-1:0]);
  assign addr_o  = row_abs * ADDR_W'(width_i) + col_abs;
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
  import tile_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic [DIM_W-1:0]  cfg_width_i,
  input  logic [DIM_W-1:0]  cfg_height_i,
  input  logic [IDX_W-1:0]  elem_idx_i,
  input  logic              tile_adv_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic              src_en_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic              dst_en_o,
  output logic              last_read_o,
  output logic              last_write_o,
  output logic              done_o
);
  logic [DIM_W-1:0] width_q, height_q;
  logic             done_q;
  logic             adv;
  tile_pos_t        rd_pos, wr_pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_q  <= '0;
      height_q <= '0;
      done_q   <= 1'b0;
    end else if (cfg_load_i) begin
      width_q  <= cfg_width_i;
      height_q <= cfg_height_i;
      done_q   <= 1'b0;
    end else if (adv && wr_pos.valid && wr_pos.last) begin
      done_q   <= 1'b1;
    end
  end

  // advances are ignored while loading and after the last store
  assign adv = tile_adv_i && !cfg_load_i && !done_q;

  tile_window_ctr i_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (cfg_load_i),
    .adv_i    (adv),
    .width_i  (width_q),
    .height_i (height_q),
    .pos_o    (rd_pos)
  );

  tile_lag_pipe #(.DEPTH(LAG)) i_lag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cfg_load_i),
    .adv_i  (adv),
    .pos_i  (rd_pos),
    .pos_o  (wr_pos)
  );

  tile_addr_calc i_src_calc (
    .row0_i  (rd_pos.row),
    .col0_i  (rd_pos.col),
    .width_i (width_q),
    .idx_i   (elem_idx_i),
    .addr_o  (src_addr_o)
  );

  tile_addr_calc i_dst_calc (
    .row0_i  (wr_pos.row),
    .col0_i  (wr_pos.col),
    .width_i (width_q),
    .idx_i   (elem_idx_i),
    .addr_o  (dst_addr_o)
  );

  assign src_en_o     = rd_pos.valid;
  assign dst_en_o     = wr_pos.valid;
  assign last_read_o  = rd_pos.valid && rd_pos.last;
  assign last_write_o = wr_pos.valid && wr_pos.last;
  assign done_o       = done_q;
endmodule

// File: rtl/tile_addr_gen_chk.sv
module tile_addr_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_load_i,
  input logic tile_adv_i,
  input logic src_en_o,
  input logic dst_en_o,
  input logic last_read_o,
  input logic last_write_o,
  input logic done_o
);
  assert_load_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |=> (src_en_o && !dst_en_o && !done_o));

  assert_drain_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_en_o && !cfg_load_i) |=> !src_en_o);

  assert_last_read_enabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_read_o |-> src_en_o);

  assert_last_write_enabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_write_o |-> dst_en_o);

  assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cfg_load_i) |=> done_o);

  assert_done_after_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_write_o && tile_adv_i && !cfg_load_i) |=> done_o);

  assert_done_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!src_en_o && !dst_en_o && !last_write_o));
endmodule

bind tile_addr_gen tile_addr_gen_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_load_i   (cfg_load_i),
  .tile_adv_i   (tile_adv_i),
  .src_en_o     (src_en_o),
  .dst_en_o     (dst_en_o),
  .last_read_o  (last_read_o),
  .last_write_o (last_write_o),
  .done_o       (done_o)
);

// File: tb/test_tile_addr_gen.sv
module test_tile_addr_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_load_i = 1'b0;
  logic [15:0] cfg_width_i = '0;
  logic [15:0] cfg_height_i = '0;
  logic [5:0]  elem_idx_i = '0;
  logic        tile_adv_i = 1'b0;
  logic [31:0] src_addr_o, dst_addr_o;
  logic        src_en_o, dst_en_o, last_read_o, last_write_o, done_o;

  tile_addr_gen i_tile_addr_gen (.*);

  always #4 clk_i = ~clk_i;

  typedef struct {
    logic        src_en;
    logic [31:0] src_addr;
    logic        dst_en;
    logic [31:0] dst_addr;
    logic        lr;
    logic        lw;
    logic        done;
    string       ctx;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;

  // reference model state
  bit loaded = 0;
  int mw, mh, cyc;

  function automatic int tiles();
    return (mw / 8) * (mh / 8);
  endfunction

  function automatic logic [31:0] addr_of(int t, int k);
    int tx, r0, c0;
    tx = mw / 8;
    r0 = (t / tx) * 8;
    c0 = (t % tx) * 8;
    return 32'((r0 + k / 8) * mw + c0 + k % 8);
  endfunction

  task automatic step(int k, bit adv, string ctx);
    exp_t e;
    int   t;
    @(negedge clk_i);
    elem_idx_i = 6'(k);
    tile_adv_i = adv;
    e.ctx = ctx;
    e.src_addr = '0;
    e.dst_addr = '0;
    if (!loaded) begin
      e.src_en = 0; e.dst_en = 0; e.lr = 0; e.lw = 0; e.done = 0;
    end else begin
      t = tiles();
      e.src_en = (cyc < t);
      e.dst_en = (cyc >= 2) && (cyc < t + 2);
      e.lr     = (cyc == t - 1);
      e.lw     = (cyc == t + 1);
      e.done   = (cyc >= t + 2);
      if (e.src_en) e.src_addr = addr_of(cyc, k);
      if (e.dst_en) e.dst_addr = addr_of(cyc - 2, k);
    end
    q.push_back(e);
    @(posedge clk_i);
    if (loaded && adv && cyc < tiles() + 2) cyc++;
  endtask

  task automatic load(int w, int h);
    @(negedge clk_i);
    cfg_load_i   = 1'b1;
    cfg_width_i  = 16'(w);
    cfg_height_i = 16'(h);
    tile_adv_i   = 1'b1; // an advance during load must be ignored (R2)
    @(posedge clk_i);
    @(negedge clk_i);
    cfg_load_i = 1'b0;
    tile_adv_i = 1'b0;
    loaded = 1;
    mw = w; mh = h; cyc = 0;
  endtask

  // one tile cycle: a few element indices, then the advance
  task automatic tile_cycle(string ctx);
    step(0, 0, ctx);
    step(7, 0, ctx);
    step(9, 0, ctx);
    step(56, 0, ctx);
    step(63, 1, ctx);
  endtask

  task automatic chk(logic [31:0] act, logic [31:0] exp, string req, string fld, string ctx);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s (%s): actual %0h expected %0h", req, fld, ctx, act, exp);
    end
  endtask

  // monitor: compares away from the clock edge
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        chk(32'(src_en_o), 32'(e.src_en), "R7", "src_en", e.ctx);
        chk(32'(dst_en_o), 32'(e.dst_en), "R6", "dst_en", e.ctx);
        chk(32'(last_read_o), 32'(e.lr), "R8", "last_read", e.ctx);
        chk(32'(last_write_o), 32'(e.lw), "R9", "last_write", e.ctx);
        chk(32'(done_o), 32'(e.done), "R9", "done", e.ctx);
        if (e.src_en) chk(src_addr_o, e.src_addr, "R3", "src_addr", e.ctx);
        if (e.dst_en) chk(dst_addr_o, e.dst_addr, "R5", "dst_addr", e.ctx);
      end
    end
  end

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    rst_ni = 1'b1;
    // R1: idle after reset, advances before any load have no effect
    step(5, 0, "R1 idle");
    step(5, 1, "R1 idle adv");
    step(63, 0, "R1 idle");

    // single tile: fill, drain and done in T+2 = 3 cycles
    load(8, 8);
    for (int i = 0; i < 3; i++) tile_cycle("R2 8x8");
    step(10, 1, "R9 adv after done");
    step(10, 1, "R9 adv after done");

    // wide image: row wrap after 3 tiles (R4)
    load(24, 16);
    for (int i = 0; i < 8; i++) tile_cycle("R4 24x16");
    step(0, 1, "R9 adv after done");

    // tall image
    load(16, 24);
    for (int i = 0; i < 8; i++) tile_cycle("R4 16x24");

    // stall: element sweep with no advance in the middle of a run
    load(40, 16);
    for (int i = 0; i < 3; i++) tile_cycle("R3 40x16");
    for (int k = 0; k < 64; k++) step(k, 0, "R5 sweep");
    for (int i = 0; i < 9; i++) tile_cycle("R3 40x16");

    // R10-style restart: reload in mid-run clears the pipeline (R2)
    load(32, 8);
    for (int i = 0; i < 3; i++) tile_cycle("R2 pre-reload");
    load(8, 16);
    for (int i = 0; i < 4; i++) tile_cycle("R2 reload 8x16");

    repeat (3) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule